// File: doc/BRIEF.md
# Composition Microprogrammed Sequencer

The block is a microprogrammed control sequencer whose state is the address of the current microcommand. An address counter selects a word in a control store. Each word holds a vector of microoperations and two flags. The continue flag keeps execution inside a straight run of microcommands, and the finish flag marks the last microcommand of the program. When the continue flag is clear, a small combinational jump network uses the current address and the condition inputs to produce the entry address of the next run. That address is loaded into the counter.

A fetch-enable flip-flop gates the whole unit. A start pulse while the unit is halted restarts the program at address zero. Reaching the finish word clears the flip-flop, and the unit then stays halted until the next start. Every output is a function of the registered address and the fetch state, so the unit is a Moore machine. A host datapath uses the microoperation vector as its control lines, and it watches `busy_o` to learn when the program has finished.

The built-in microprogram has eight words in three runs. Run A is addresses 0–1. Run B is addresses 2–4 and can be entered at 2 or at 3. Run C is addresses 5–7.

Top module: `cmcu_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) leaves `busy_o`=0, `addr_o`=0 and `mop_o`=0 after that edge. A reset during a run also stops the run.
- R2: `start_i` high at an edge while `busy_o`=0 gives, after that edge, `busy_o`=1, `addr_o`=0 and `mop_o`=6'b000001.
- R3: While busy, at an address whose word has the continue flag set (addresses 0, 2, 3, 5 and 6), the next edge advances `addr_o` by one.
- R4: While busy at address 1, the end of run A, the next address depends on the condition inputs, with `cond_i[0]`=x1 and `cond_i[1]`=x2. If x1=1 it goes to 2. If x1=0 and x2=1 it goes to 3. If both are 0 it goes to 5.
- R5: While busy at address 4, the end of run B, the next address is 5 whatever the conditions.
- R6: Address 7 is the finish word. It drives its microoperations for one cycle. After the next edge `busy_o`=0, `mop_o`=0 and `addr_o` stays 7.
- R7: `start_i` has no effect while `busy_o`=1. The program continues unchanged.
- R8: The condition inputs are looked at only in a cycle whose word has the continue flag clear. Changing them at any other point has no effect on the address sequence.
- R9: While `busy_o`=0, `mop_o` is all zeros, and absent reset or start, `addr_o` holds.
- R10: While busy, `mop_o` equals the microoperations of the word at `addr_o`. Addresses 0 to 7 hold, in order, 000001, 000010, 000100, 001000, 010001, 100000, 000110 and 101000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart the program at address 0 when halted |
| cond_i | input | 2 | Logical conditions, bit 0 = x1, bit 1 = x2 |
| mop_o | output | 6 | Microoperation vector, zero while halted |
| busy_o | output | 1 | Fetch enabled (program running) |
| addr_o | output | 3 | Current microcommand address (state code) |

## Verification
The program is run once for each of the four condition patterns. The 1x and 01 patterns both leave run A but enter run B at different points, and 00 skips run B completely, so a wrong priority or a wrong entry address gives a different address trace. Further runs change the conditions on every cycle except the run A exit cycle, which separates a design that samples the conditions only at a chain exit from one that reacts to them at other times. A start pulse is injected in the middle of each run, and a reset is applied part-way through one run, to check that the program is not disturbed by the pulse and is aborted by the reset.

// File: rtl/cmcu_pkg.sv
package cmcu_pkg;

  localparam int CM_ADDR_W = 3;
  localparam int CM_COND_W = 2;
  localparam int CM_MOP_W  = 6;
  localparam int CM_WORDS  = 1 << CM_ADDR_W;

  // chain exits, entries and the finishing word of the built-in program
  localparam logic [CM_ADDR_W-1:0] CM_EXIT_A  = 3'd1;
  localparam logic [CM_ADDR_W-1:0] CM_EXIT_B  = 3'd4;
  localparam logic [CM_ADDR_W-1:0] CM_LAST    = 3'd7;
  localparam logic [CM_ADDR_W-1:0] CM_ENT_B0  = 3'd2;
  localparam logic [CM_ADDR_W-1:0] CM_ENT_B1  = 3'd3;
  localparam logic [CM_ADDR_W-1:0] CM_ENT_C   = 3'd5;

  typedef struct packed {
    logic [CM_MOP_W-1:0] mop;
    logic                cont;
    logic                fin;
  } cm_word_t;

  function automatic cm_word_t cm_word(input logic [CM_ADDR_W-1:0] a);
    cm_word_t w;
    w = '0;
    case (a)
      3'd0: w = '{mop: 6'b000001, cont: 1'b1, fin: 1'b0};
      3'd1: w = '{mop: 6'b000010, cont: 1'b0, fin: 1'b0};
      3'd2: w = '{mop: 6'b000100, cont: 1'b1, fin: 1'b0};
      3'd3: w = '{mop: 6'b001000, cont: 1'b1, fin: 1'b0};
      3'd4: w = '{mop: 6'b010001, cont: 1'b0, fin: 1'b0};
      3'd5: w = '{mop: 6'b100000, cont: 1'b1, fin: 1'b0};
      3'd6: w = '{mop: 6'b000110, cont: 1'b1, fin: 1'b0};
      default: w = '{mop: 6'b101000, cont: 1'b0, fin: 1'b1};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cmcu_ctrl_store.sv
module cmcu_ctrl_store
  import cmcu_pkg::*;
#(
  parameter int ADDR_W = CM_ADDR_W
) (
  input  logic              clk_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output cm_word_t          word_o
);

  // registered read of a constant table: maps onto a block-RAM ROM
  cm_word_t word_q;

  always_ff @(posedge clk_i) begin
    word_q <= cm_word(rd_addr_i);
  end

  assign word_o = word_q;

endmodule

// File: rtl/cmcu_jump_net.sv
module cmcu_jump_net
  import cmcu_pkg::*;
#(
  parameter int ADDR_W = CM_ADDR_W,
  parameter int COND_W = CM_COND_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [ADDR_W-1:0] entry_o
);

  always_comb begin
    entry_o = '0;
    case (addr_i)
      CM_EXIT_A: begin
        if (cond_i[0])      entry_o = CM_ENT_B0;
        else if (cond_i[1]) entry_o = CM_ENT_B1;
        else                entry_o = CM_ENT_C;
      end
      CM_EXIT_B: entry_o = CM_ENT_C;
      default:   entry_o = '0;
    endcase
  end

endmodule

// File: rtl/cmcu_addr_ctr.sv
module cmcu_addr_ctr #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         go_i,
  input  logic         hold_i,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);

  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (rst_i || go_i) cnt_nxt_o = '0;
    else if (hold_i)   cnt_nxt_o = cnt_q;
    else if (step_i)   cnt_nxt_o = cnt_q + W'(1);
    else if (load_i)   cnt_nxt_o = load_val_i;
  end

  always_ff @(posedge clk_i) begin
    cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/cmcu_fetch_ff.sv
module cmcu_fetch_ff (
  input  logic clk_i,
  input  logic rst_i,
  input  logic go_i,
  input  logic fin_i,
  output logic fetch_o
);

  logic fetch_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                 fetch_q <= 1'b0;
    else if (go_i)             fetch_q <= 1'b1;
    else if (fetch_q && fin_i) fetch_q <= 1'b0;
  end

  assign fetch_o = fetch_q;

endmodule

// File: rtl/cmcu_seq.sv
module cmcu_seq
  import cmcu_pkg::*;
#(
  parameter int ADDR_W = CM_ADDR_W,
  parameter int COND_W = CM_COND_W,
  parameter int MOP_W  = CM_MOP_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [MOP_W-1:0]  mop_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              fetch;
  logic              go;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] entry;
  cm_word_t          word;

  assign go = start_i && !fetch;

  cmcu_fetch_ff u_fetch (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .go_i    (go),
    .fin_i   (word.fin),
    .fetch_o (fetch)
  );

  cmcu_jump_net #(.ADDR_W(ADDR_W), .COND_W(COND_W)) u_jump (
    .addr_i  (addr_q),
    .cond_i  (cond_i),
    .entry_o (entry)
  );

  cmcu_addr_ctr #(.W(ADDR_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .go_i       (go),
    .hold_i     (!fetch || word.fin),
    .step_i     (word.cont),
    .load_i     (!word.cont),
    .load_val_i (entry),
    .cnt_o      (addr_q),
    .cnt_nxt_o  (addr_nxt)
  );

  // store is addressed with the next count so its word lines up with addr_q
  cmcu_ctrl_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .rd_addr_i (addr_nxt),
    .word_o    (word)
  );

  assign mop_o  = fetch ? word.mop : '0;
  assign busy_o = fetch;
  assign addr_o = addr_q;

endmodule

// File: rtl/cmcu_seq_chk.sv
module cmcu_seq_chk
  import cmcu_pkg::*;
(
  input logic       clk_i,
  input logic       rst_i,
  input logic       start_i,
  input logic [1:0] cond_i,
  input logic [5:0] mop_o,
  input logic       busy_o,
  input logic [2:0] addr_o
);

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (!busy_o && addr_o == 3'd0 && mop_o == 6'd0));

  // R2
  start_go_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !busy_o) |=> (busy_o && addr_o == 3'd0));

  // R3
  chain_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o != CM_EXIT_A && addr_o != CM_EXIT_B && addr_o != CM_LAST)
      |=> (addr_o == $past(addr_o) + 3'd1));

  // R4
  jump_x1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o == CM_EXIT_A && cond_i[0]) |=> (addr_o == 3'd2));

  // R4
  jump_x2_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o == CM_EXIT_A && cond_i == 2'b10) |=> (addr_o == 3'd3));

  // R4
  jump_none_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o == CM_EXIT_A && cond_i == 2'b00) |=> (addr_o == 3'd5));

  // R5
  exit_b_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o == CM_EXIT_B) |=> (addr_o == 3'd5));

  // R6
  finish_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o == CM_LAST) |=> (!busy_o && addr_o == CM_LAST));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_o && addr_o != CM_LAST) |=> busy_o);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |-> (mop_o == 6'd0));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_o && !start_i) |=> $stable(addr_o));

endmodule

bind cmcu_seq cmcu_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .start_i (start_i),
  .cond_i  (cond_i),
  .mop_o   (mop_o),
  .busy_o  (busy_o),
  .addr_o  (addr_o)
);

// File: tb/cmcu_seq_tb_top.sv
`timescale 1ns/1ps
module cmcu_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [1:0] cond;
  logic [5:0] mop;
  logic       busy;
  logic [2:0] addr;

  always #5 clk = ~clk;

  cmcu_seq dut_i (
    .clk_i   (clk),
    .rst_i   (rst),
    .start_i (start),
    .cond_i  (cond),
    .mop_o   (mop),
    .busy_o  (busy),
    .addr_o  (addr)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference
  int    m_addr = 0;
  bit    m_busy = 0;
  string m_tag  = "R1";
  bit    scramble = 0;
  logic [1:0] xexit = 2'b00;
  logic [7:0] noise = 8'h5a;
  int    seen[$];

  function automatic logic [5:0] exp_mop(input int a);
    case (a)
      0: return 6'b000001;
      1: return 6'b000010;
      2: return 6'b000100;
      3: return 6'b001000;
      4: return 6'b010001;
      5: return 6'b100000;
      6: return 6'b000110;
      default: return 6'b101000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_busy = 0; m_tag = "R1";
    end else if (!m_busy) begin
      if (start) begin m_addr = 0; m_busy = 1; m_tag = "R2"; end
      else m_tag = "R9";
    end else begin
      if (m_addr == 7) begin m_busy = 0; m_tag = "R6"; end
      else if (m_addr == 1) begin
        m_addr = cond[0] ? 2 : (cond[1] ? 3 : 5);
        m_tag = "R4";
      end else if (m_addr == 4) begin m_addr = 5; m_tag = "R5"; end
      else begin m_addr = m_addr + 1; m_tag = scramble ? "R8" : "R3"; end
      if (start && m_busy) m_tag = "R7";
    end
  end

  // compare and drive conditions away from the active edge
  always @(negedge clk) begin
    logic [5:0] em;
    em = m_busy ? exp_mop(m_addr) : 6'd0;
    checks++;
    if (busy !== m_busy || addr !== m_addr[2:0] || mop !== em) begin
      errors++;
      $display("FAIL %s/R10 t=%0t: busy=%0b addr=%0d mop=%b, expected busy=%0b addr=%0d mop=%b",
               m_tag, $time, busy, addr, mop, m_busy, m_addr, em);
    end
    if (m_busy) seen.push_back(m_addr);
    noise = {noise[6:0], noise[7] ^ noise[5] ^ noise[4] ^ noise[3]};
    if (scramble) cond = (m_busy && m_addr == 1) ? xexit : noise[1:0];
    else          cond = xexit;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected at most 20000", cycles);
      summary();
      $finish;
    end
  end

  task automatic run(input logic [1:0] xe, input bit scr, input int abort_at);
    int exp_q[$];
    int n;
    string tag;
    xexit = xe; scramble = scr;
    @(negedge clk);
    seen.delete();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (m_busy && n < 50) begin
      @(negedge clk);
      n++;
      start = (n == 2);
      rst = (abort_at != 0 && n == abort_at);
    end
    start = 1'b0; rst = 1'b0;
    if (abort_at != 0) begin
      // R1: reset mid-run stops the program at address 0
      checks++;
      if (busy !== 1'b0 || addr !== 3'd0) begin
        errors++;
        $display("FAIL R1 abort: busy=%0b addr=%0d, expected busy=0 addr=0", busy, addr);
      end
      return;
    end
    exp_q = {0, 1};
    if (xe[0]) exp_q = {exp_q, 2, 3, 4};
    else if (xe[1]) exp_q = {exp_q, 3, 4};
    exp_q = {exp_q, 5, 6, 7};
    tag = scr ? "R8" : "R4";
    checks++;
    if (seen != exp_q) begin
      errors++;
      $display("FAIL %s cond=%b: trace %p, expected %p", tag, xe, seen, exp_q);
    end
    // R6: halted on the finish word
    checks++;
    if (busy !== 1'b0 || mop !== 6'd0 || addr !== 3'd7) begin
      errors++;
      $display("FAIL R6 halt: busy=%0b mop=%b addr=%0d, expected 0 000000 7", busy, mop, addr);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; cond = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (busy !== 1'b0 || addr !== 3'd0 || mop !== 6'd0) begin
      errors++;
      $display("FAIL R1 reset: busy=%0b addr=%0d mop=%b, expected 0 0 000000", busy, addr, mop);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run(2'b01, 1'b0, 0);
    run(2'b11, 1'b0, 0);
    run(2'b10, 1'b0, 0);
    run(2'b00, 1'b0, 0);
    run(2'b01, 1'b1, 0);
    run(2'b10, 1'b1, 0);
    run(2'b00, 1'b1, 0);
    run(2'b01, 1'b0, 4);
    repeat (2) @(negedge clk);
    run(2'b10, 1'b0, 0);
    summary();
    $finish;
  end

endmodule